// File: doc/BRIEF.md
# Context-Cache Invalidation Command Register

This block is a 64-bit memory-mapped command register. Software uses it to ask for a context-cache invalidation and then polls it to see when the work is finished. A bus write that covers the top byte and sets the command bit starts a request. The requested granularity, domain identifier and source identifier are carried in the same register.

A small sequencer then performs the request. If the `FLUSH_EN` parameter is set, it first runs a write-buffer flush handshake. It then presents the invalidation to a cache-control port and holds it until the port acknowledges. One cycle after the acknowledge, the command bit clears itself. At the same time, the granularity the cache reports it actually used is latched into a read-only field.

Any bus write that arrives while a request is pending is dropped. Reads always return the live register contents.

Top module: `ctxinv_cmd_reg`

## Requirements
- R1: After reset the register reads `0800_0000_0000_0000h`. A read at byte address `REG_OFS` (default 28h) returns the live register, and a read at any other address returns 0.
- R2: An accepted write updates only the byte lanes whose enable bit is set, and within them only the writable fields. The writable fields are bit 63 (command), bits 62:61 (requested granularity), bits 31:16 (source ID) and bits 15:0 (domain ID). Bits 60:59 (actual granularity) and the reserved bits 58:32 ignore writes, and the reserved bits read as 0. A write at any address other than `REG_OFS` changes nothing.
- R3: A request starts only when a write at `REG_OFS` has byte enable 7 set and data bit 63 set. Bit 63 then reads 1 until the request completes. A write whose byte enable 7 is clear never starts a request, whatever its bit 63 is.
- R4: With `FLUSH_EN`=1, `wbf_req` is raised first and `inv_req` rises only after `wbf_ack` has been seen. With `FLUSH_EN`=0, `wbf_req` is never raised.
- R5: `inv_req` presents the requested granularity on `inv_gran`, the domain ID on `inv_dom` and the source ID on `inv_src`. It stays high, with those values stable, until `inv_ack` is sampled high.
- R6: One clock edge after `inv_ack` is sampled with `inv_req` high, bit 63 still reads 1. At the next edge bit 63 clears and bits 60:59 take the value of `inv_ack_gran` that was sampled with the acknowledge. The granularity encoding is 01 global, 10 domain, 11 device.
- R7: A request with requested granularity 00 raises neither `wbf_req` nor `inv_req`. It completes by itself: bit 63 clears at the second edge after the starting write, and bits 60:59 read 00.
- R8: While bit 63 is set, every write at `REG_OFS` is ignored in full.
- R9: A pulse on `wbf_ack` or `inv_ack` while no matching request is outstanding has no effect on the register or on the request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_be | input | 8 | Byte enables, bit i covers data bits 8i+7:8i |
| wr_data | input | 64 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 64 | Read data |
| wbf_req | output | 1 | Write-buffer flush request |
| wbf_ack | input | 1 | Write-buffer flush acknowledge pulse |
| inv_req | output | 1 | Context-cache invalidation request |
| inv_gran | output | 2 | Requested granularity |
| inv_dom | output | 16 | Domain ID of the request |
| inv_src | output | 16 | Source ID of the request |
| inv_ack | input | 1 | Invalidation acknowledge pulse |
| inv_ack_gran | input | 2 | Granularity actually used, valid with `inv_ack` |

## Verification
Two functions can fall in the same cycle. One is a software write to the register. The other is the sequencer's own update, either the hand-off between phases or the completion that clears bit 63. The bench provokes this by issuing a full write on every byte lane while `inv_req` is held waiting for its acknowledge. It then checks that the request outputs stay unchanged and that the register still reads its request fields. It also checks that the completion cycle, when it comes, writes only the clear command bit and the reported granularity. Stray acknowledges sent while the sequencer is idle are judged the same way: at the ports, one cycle later.

// File: rtl/ctxinv_pkg.sv
package ctxinv_pkg;

  localparam int REG_W  = 64;
  localparam int NBYTES = REG_W / 8;
  localparam int GR_W   = 2;
  localparam int ID_W   = 16;

  // field positions
  localparam int ICC_B  = 63;
  localparam int RG_LO  = 61;
  localparam int AG_LO  = 59;
  localparam int SRC_LO = 16;
  localparam int DOM_LO = 0;

  localparam logic [REG_W-1:0] RW_MASK = 64'hE000_0000_FFFF_FFFF;
  localparam logic [REG_W-1:0] RST_VAL = 64'h0800_0000_0000_0000;

  typedef logic [GR_W-1:0] gran_t;
  localparam gran_t GR_NONE = 2'b00;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FLUSH,
    SEQ_INVAL,
    SEQ_DONE
  } seq_e;

  // expand byte enables into a bit mask
  function automatic logic [REG_W-1:0] be_to_mask(input logic [NBYTES-1:0] be);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NBYTES; i++) begin
      m[i*8 +: 8] = {8{be[i]}};
    end
    return m;
  endfunction

  // merge a bus write into the current value, writable fields only
  function automatic logic [REG_W-1:0] merge_write(input logic [REG_W-1:0] old_v,
                                                   input logic [REG_W-1:0] data,
                                                   input logic [NBYTES-1:0] be);
    logic [REG_W-1:0] m;
    m = be_to_mask(be) & RW_MASK;
    return (old_v & ~m) | (data & m);
  endfunction

  function automatic gran_t field_req_gran(input logic [REG_W-1:0] r);
    return r[RG_LO +: GR_W];
  endfunction

  function automatic logic [ID_W-1:0] field_src(input logic [REG_W-1:0] r);
    return r[SRC_LO +: ID_W];
  endfunction

  function automatic logic [ID_W-1:0] field_dom(input logic [REG_W-1:0] r);
    return r[DOM_LO +: ID_W];
  endfunction

  // completion update: drop command bit, record granularity used
  function automatic logic [REG_W-1:0] apply_result(input logic [REG_W-1:0] r,
                                                    input gran_t g);
    logic [REG_W-1:0] v;
    v = r;
    v[ICC_B] = 1'b0;
    v[AG_LO +: GR_W] = g;
    return v;
  endfunction

endpackage

// File: rtl/ctxinv_wr_decode.sv
module ctxinv_wr_decode
  import ctxinv_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'h028
) (
  input  logic                wr_valid,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NBYTES-1:0]   wr_be,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [REG_W-1:0]    cur_reg,
  output logic                wr_take,
  output logic                wr_blocked,
  output logic                start_evt,
  output logic [REG_W-1:0]    merged
);

  logic hit;
  logic busy;

  always_comb begin
    hit        = wr_valid && (wr_addr == REG_OFS);
    busy       = cur_reg[ICC_B];
    wr_take    = hit && !busy;
    wr_blocked = hit && busy;
    start_evt  = wr_take && wr_be[NBYTES-1] && wr_data[ICC_B];
    merged     = merge_write(cur_reg, wr_data, wr_be);
  end

endmodule

// File: rtl/ctxinv_seq.sv
module ctxinv_seq
  import ctxinv_pkg::*;
#(
  parameter bit FLUSH_EN = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_evt,
  input  gran_t  start_gran,
  input  logic   wbf_ack,
  input  logic   inv_ack,
  input  gran_t  inv_ack_gran,
  output logic   wbf_req,
  output logic   inv_req,
  output logic   done_evt,
  output gran_t  done_gran
);

  seq_e  state_q, state_d;
  gran_t res_q, res_d;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_evt) begin
          if (start_gran == GR_NONE) begin
            state_d = SEQ_DONE;
            res_d   = GR_NONE;
          end else if (FLUSH_EN) begin
            state_d = SEQ_FLUSH;
          end else begin
            state_d = SEQ_INVAL;
          end
        end
      end
      SEQ_FLUSH: begin
        if (wbf_ack) state_d = SEQ_INVAL;
      end
      SEQ_INVAL: begin
        if (inv_ack) begin
          state_d = SEQ_DONE;
          res_d   = inv_ack_gran;
        end
      end
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      res_q   <= GR_NONE;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  assign wbf_req   = (state_q == SEQ_FLUSH);
  assign inv_req   = (state_q == SEQ_INVAL);
  assign done_evt  = (state_q == SEQ_DONE);
  assign done_gran = res_q;

endmodule

// File: rtl/ctxinv_regs.sv
module ctxinv_regs
  import ctxinv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_take,
  input  logic [REG_W-1:0] merged,
  input  logic             done_evt,
  input  gran_t            done_gran,
  output logic [REG_W-1:0] reg_q
);

  // done_evt and wr_take never coincide: writes are refused while bit 63 is set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= RST_VAL;
    end else if (done_evt) begin
      reg_q <= apply_result(reg_q, done_gran);
    end else if (wr_take) begin
      reg_q <= merged;
    end
  end

endmodule

// File: rtl/ctxinv_cmd_reg.sv
module ctxinv_cmd_reg
  import ctxinv_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'h028,
  parameter bit FLUSH_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_be,
  input  logic [63:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_data,
  output logic              wbf_req,
  input  logic              wbf_ack,
  output logic              inv_req,
  output logic [1:0]        inv_gran,
  output logic [15:0]       inv_dom,
  output logic [15:0]       inv_src,
  input  logic              inv_ack,
  input  logic [1:0]        inv_ack_gran
);

  // named internal events, observed by the bound checker
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] merged;
  logic             wr_take;
  logic             wr_blocked;
  logic             start_evt;
  logic             done_evt;
  gran_t            done_gran;

  ctxinv_wr_decode #(
    .ADDR_W  (ADDR_W),
    .REG_OFS (REG_OFS)
  ) dec_i (
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_be      (wr_be),
    .wr_data    (wr_data),
    .cur_reg    (reg_q),
    .wr_take    (wr_take),
    .wr_blocked (wr_blocked),
    .start_evt  (start_evt),
    .merged     (merged)
  );

  ctxinv_seq #(
    .FLUSH_EN (FLUSH_EN)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_evt    (start_evt),
    .start_gran   (field_req_gran(merged)),
    .wbf_ack      (wbf_ack),
    .inv_ack      (inv_ack),
    .inv_ack_gran (inv_ack_gran),
    .wbf_req      (wbf_req),
    .inv_req      (inv_req),
    .done_evt     (done_evt),
    .done_gran    (done_gran)
  );

  ctxinv_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_take   (wr_take),
    .merged    (merged),
    .done_evt  (done_evt),
    .done_gran (done_gran),
    .reg_q     (reg_q)
  );

  assign rd_data  = (rd_addr == REG_OFS) ? reg_q : '0;
  assign inv_gran = field_req_gran(reg_q);
  assign inv_dom  = field_dom(reg_q);
  assign inv_src  = field_src(reg_q);

endmodule

// File: rtl/ctxinv_cmd_chk.sv
module ctxinv_cmd_chk #(
  parameter bit FLUSH_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [7:0]  wr_be,
  input logic [63:0] wr_data,
  input logic        wbf_req,
  input logic        wbf_ack,
  input logic        inv_req,
  input logic        inv_ack,
  input logic [1:0]  inv_gran,
  input logic [15:0] inv_dom,
  input logic [15:0] inv_src,
  input logic [63:0] reg_q,
  input logic        wr_blocked
);

  AST_START_FROM_TOP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_q[63]) |-> $past(wr_valid && wr_be[7] && wr_data[63])); // R3

  AST_INV_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (FLUSH_EN && $rose(inv_req)) |-> $past(wbf_ack)); // R4

  AST_NO_FLUSH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!FLUSH_EN) |-> !wbf_req); // R4

  AST_INV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_ack) |=> (inv_req && $stable(inv_gran) && $stable(inv_dom)
                               && $stable(inv_src))); // R5

  AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_ack) |=> reg_q[63] ##1 !reg_q[63]); // R6

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[63] && reg_q[62:61] == 2'b00) |-> (!inv_req && !wbf_req)); // R7

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> ($stable(reg_q[62:61]) && $stable(reg_q[31:0]))); // R8

  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_q[63] && !wr_valid && (inv_ack || wbf_ack)) |=> $stable(reg_q)); // R9

endmodule

bind ctxinv_cmd_reg ctxinv_cmd_chk #(.FLUSH_EN(FLUSH_EN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_be      (wr_be),
  .wr_data    (wr_data),
  .wbf_req    (wbf_req),
  .wbf_ack    (wbf_ack),
  .inv_req    (inv_req),
  .inv_ack    (inv_ack),
  .inv_gran   (inv_gran),
  .inv_dom    (inv_dom),
  .inv_src    (inv_src),
  .reg_q      (reg_q),
  .wr_blocked (wr_blocked)
);

// File: tb/ctxinv_cmd_reg_tb.sv
module ctxinv_cmd_reg_tb_top;

  localparam logic [11:0] OFS = 12'h028;
  localparam logic [63:0] WMASK = 64'hE000_0000_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr_valid = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic [11:0] rd_addr = OFS;
  logic        sel = 1'b0;  // 0: flush variant, 1: no-flush variant
  logic        wbf_ack = 1'b0, inv_ack = 1'b0;
  logic [1:0]  ack_gran = '0;

  logic [63:0] rd_f, rd_n;
  logic        wreq_f, wreq_n, ireq_f, ireq_n;
  logic [1:0]  ig_f, ig_n;
  logic [15:0] id_f, id_n, is_f, is_n;

  ctxinv_cmd_reg #(.FLUSH_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid && !sel), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_f),
    .wbf_req(wreq_f), .wbf_ack(wbf_ack && !sel), .inv_req(ireq_f), .inv_gran(ig_f),
    .inv_dom(id_f), .inv_src(is_f), .inv_ack(inv_ack && !sel), .inv_ack_gran(ack_gran));

  ctxinv_cmd_reg #(.FLUSH_EN(1'b0)) dut_nf_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid && sel), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_n),
    .wbf_req(wreq_n), .wbf_ack(wbf_ack && sel), .inv_req(ireq_n), .inv_gran(ig_n),
    .inv_dom(id_n), .inv_src(is_n), .inv_ack(inv_ack && sel), .inv_ack_gran(ack_gran));

  wire [63:0] rd   = sel ? rd_n : rd_f;
  wire        wreq = sel ? wreq_n : wreq_f;
  wire        ireq = sel ? ireq_n : ireq_f;
  wire [1:0]  igr  = sel ? ig_n : ig_f;
  wire [15:0] idm  = sel ? id_n : id_f;
  wire [15:0] isr  = sel ? is_n : is_f;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] model [2];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus write; returns at the falling edge after the capturing edge
  task automatic bus_write(input logic [11:0] a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_be = '0;
  endtask

  function automatic logic [63:0] lane_mask(input logic [7:0] be);
    logic [63:0] m = '0;
    for (int b = 0; b < 8; b++) if (be[b]) m = m | (64'hFF << (8 * b));
    return m;
  endfunction

  task automatic run_cmd(input logic [1:0] g, input logic [15:0] src,
                         input logic [15:0] dom, input logic [1:0] ag);
    logic [63:0] d, pend, fin;
    int v;
    v = sel ? 1 : 0;
    d = {1'b1, g, 2'b11, {27{1'b1}}, src, dom};
    pend = {1'b1, g, model[v][60:59], 27'b0, src, dom};
    fin  = {1'b0, g, (g == 2'b00) ? 2'b00 : ag, 27'b0, src, dom};
    bus_write(OFS, 8'hFF, d);
    chk(rd == pend, "R3 pending readback", rd, pend);
    if (g == 2'b00) begin
      chk(!wreq && !ireq, "R7 no request for code 00", {62'b0, wreq, ireq}, 64'd0);
      @(negedge clk);
      chk(rd == fin, "R7 self-complete", rd, fin);
    end else begin
      if (!sel) begin
        chk(wreq && !ireq, "R4 flush first", {62'b0, wreq, ireq}, 64'd2);
        wbf_ack = 1'b1;
        @(negedge clk);
        wbf_ack = 1'b0;
      end else begin
        chk(!wreq, "R4 no flush when disabled", {63'b0, wreq}, 64'd0);
      end
      chk(ireq && igr == g && idm == dom && isr == src, "R5 request fields",
          {igr, isr, idm}, {g, src, dom});
      // write during pending, all lanes
      bus_write(OFS, 8'hFF, ~d);
      chk(ireq && igr == g, "R5 request held", {63'b0, ireq}, 64'd1);
      chk(rd == pend, "R8 write ignored while pending", rd, pend);
      inv_ack = 1'b1; ack_gran = ag;
      @(negedge clk);
      inv_ack = 1'b0; ack_gran = ~ag;
      chk(rd[63] == 1'b1, "R6 bit 63 one cycle after ack", rd, pend);
      @(negedge clk);
      chk(rd == fin, "R6 completion value", rd, fin);
    end
    model[v] = fin;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model[0] = 64'h0800_0000_0000_0000;
    model[1] = 64'h0800_0000_0000_0000;
    chk(rd == model[0], "R1 reset value", rd, model[0]);
    rd_addr = 12'h020;
    #1 chk(rd == 64'd0, "R1 other address reads zero", rd, 64'd0);
    rd_addr = OFS;

    // byte-enable sweep; bit 63 set only where lane 7 is off (R3: no start)
    for (int be = 0; be < 256; be++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      d[63] = ~be[7];
      bus_write(OFS, be[7:0], d);
      model[0] = (model[0] & ~(lane_mask(be[7:0]) & WMASK)) | (d & lane_mask(be[7:0]) & WMASK);
      chk(rd == model[0] && !wreq && !ireq, "R2 R3 byte-enable write", rd, model[0]);
    end

    bus_write(12'h030, 8'hFF, 64'h1234_5678_9ABC_DEF0);
    chk(rd == model[0], "R2 other address write ignored", rd, model[0]);

    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      for (int g = 0; g < 4; g++) begin
        for (int a = 1; a < 4; a++) begin
          run_cmd(g[1:0], 16'hA500 + 16'(g * 4 + a), 16'h0F00 + 16'(s * 16 + a), a[1:0]);
        end
      end
    end

    // stray acknowledges while idle (R9)
    sel = 1'b0;
    @(negedge clk);
    wbf_ack = 1'b1; inv_ack = 1'b1; ack_gran = 2'b00;
    @(negedge clk);
    wbf_ack = 1'b0; inv_ack = 1'b0;
    @(negedge clk);
    chk(rd == model[0] && !wreq && !ireq, "R9 stray ack ignored", rd, model[0]);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule